// File: doc/BRIEF.md
# Receive Alarm Interrupt Controller

This block gathers the alarm and event indications of a DS3 receive path and folds them into a single active-high interrupt request for a host processor. Six inputs are level conditions: loss of signal, out of frame, alarm indication, idle, far-end receive failure and the application identification bit. Each of these raises an interrupt whenever it changes state, in either direction. Five inputs are one-cycle event strobes: parity-bit error, CP-bit error, FEAC message validated, FEAC message removed and LAPD message received.

Each source latches into a sticky status bit. Every status bit has its own source enable, and one block-level enable gates the whole receive section. A small register bus lets the host write the enables, read the sticky bits (a status read clears them), and read the live level of the six conditions.

The bus responder is a two-state machine. BUS_IDLE moves to BUS_RESP on a read strobe. BUS_RESP stays in BUS_RESP when another read strobe arrives and returns to BUS_IDLE otherwise. `rd_valid` is high exactly while the machine is in BUS_RESP.

Top module: `rx_alarm_irq`

## Requirements
- R1: After reset every enable and sticky bit is 0, `irq` is low, `rd_valid` is low, and all status registers read 0.
- R2: A change of any level input, rising or falling, sets its bit in the level status register (address 0x11). The bit map is LOS=0, OOF=1, AIS=2, idle=3, FERF=4, AIC=5. The bit can be read on the first clock edge after the input changed.
- R3: A one-cycle event pulse sets its bit in the event status register (address 0x13). The bit map is P-bit error=0, CP-bit error=1, FEAC validated=2, FEAC removed=3, LAPD received=4.
- R4: A sticky bit is set by its trigger whatever its source enable holds, and it stays set until the host reads it.
- R5: A read strobe produces `rd_valid` for one cycle on the next edge. The data returned is the register value before the read. A read of 0x11 or 0x13 clears that register.
- R6: `irq` is high exactly when the block enable (bit 7 of address 0x04) is set and some sticky bit has its source enable set. The level enables are at 0x10 and the event enables are at 0x12, with the same bit maps as their status registers.
- R7: `irq` falls in the cycle after the read that clears the last enabled pending bit.
- R8: Address 0x14 returns the registered live value of the six level inputs, using the R2 bit map. It is read-only.
- R9: A trigger that arrives in the same cycle as a clearing read of its register leaves its bit set. That read returns the old value.
- R10: The enable registers read back what was written. Address 0x04 returns only bit 7. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_in | input | 6 | Level alarm conditions (R2 bit map) |
| evt_in | input | 5 | One-cycle event strobes (R3 bit map) |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: six level sources, five event sources, an 8-bit bus and the block enable at bit 7. This setting makes every bit of every register reachable. It lets the bench toggle levels in both directions, enable one source while another stays masked, and turn the block enable off and on while a bit is pending. It also lands an event strobe on the same edge as a clearing read, which exercises the collision case.

// File: rtl/rx_alarm_irq_pkg.sv
package rx_alarm_irq_pkg;
    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;
endpackage

// File: rtl/rxa_change_det.sv
module rxa_change_det #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] chg_o,
    output logic [N-1:0] level_q_o
);
    logic         primed_q;
    logic [N-1:0] level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            level_q  <= '0;
        end else begin
            primed_q <= 1'b1;
            level_q  <= level_i;
        end
    end

    assign chg_o     = primed_q ? (level_i ^ level_q) : '0;
    assign level_q_o = level_q;
endmodule

// File: rtl/rxa_sticky.sv
module rxa_sticky #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] sticky_o
);
    logic [N-1:0] sticky_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) sticky_q[g] <= 1'b0;
            else        sticky_q[g] <= set_i[g] | (sticky_q[g] & ~clr_i);
        end

        // R4
        sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> sticky_q[g]);
    end

    // R5
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> sticky_q == '0);

    assign sticky_o = sticky_q;
endmodule

// File: rtl/rxa_regbank.sv
module rxa_regbank
    import rx_alarm_irq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int N_LVL   = 6,
    parameter int N_EVT   = 5,
    parameter int BLK_BIT = 7,
    parameter logic [ADDR_W-1:0] A_BLK = 8'h04,
    parameter logic [ADDR_W-1:0] A_LEN = 8'h10,
    parameter logic [ADDR_W-1:0] A_LST = 8'h11,
    parameter logic [ADDR_W-1:0] A_EEN = 8'h12,
    parameter logic [ADDR_W-1:0] A_EST = 8'h13,
    parameter logic [ADDR_W-1:0] A_LIV = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    input  logic [N_LVL-1:0]  lvl_st_i,
    input  logic [N_EVT-1:0]  evt_st_i,
    input  logic [N_LVL-1:0]  lvl_now_i,
    output logic [N_LVL-1:0]  lvl_en_o,
    output logic [N_EVT-1:0]  evt_en_o,
    output logic              blk_en_o,
    output logic              lvl_clr_o,
    output logic              evt_clr_o
);
    localparam int LPAD = DATA_W - N_LVL;
    localparam int EPAD = DATA_W - N_EVT;

    bus_state_t        state_q, state_d;
    logic [DATA_W-1:0] rdata_q, rmux;
    logic [N_LVL-1:0]  lvl_en_q;
    logic [N_EVT-1:0]  evt_en_q;
    logic              blk_en_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_i) state_d = BUS_RESP;
            BUS_RESP: if (!rd_i) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        rmux = '0;
        if (addr_i == A_BLK) rmux[BLK_BIT] = blk_en_q;
        else if (addr_i == A_LEN) rmux = {{LPAD{1'b0}}, lvl_en_q};
        else if (addr_i == A_LST) rmux = {{LPAD{1'b0}}, lvl_st_i};
        else if (addr_i == A_EEN) rmux = {{EPAD{1'b0}}, evt_en_q};
        else if (addr_i == A_EST) rmux = {{EPAD{1'b0}}, evt_st_i};
        else if (addr_i == A_LIV) rmux = {{LPAD{1'b0}}, lvl_now_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            lvl_en_q <= '0;
            evt_en_q <= '0;
            blk_en_q <= 1'b0;
        end else begin
            if (rd_i) rdata_q <= rmux;
            if (wr_i) begin
                if (addr_i == A_BLK) blk_en_q <= wdata_i[BLK_BIT];
                if (addr_i == A_LEN) lvl_en_q <= wdata_i[N_LVL-1:0];
                if (addr_i == A_EEN) evt_en_q <= wdata_i[N_EVT-1:0];
            end
        end
    end

    assign rvalid_o  = (state_q == BUS_RESP);
    assign rdata_o   = rdata_q;
    assign lvl_en_o  = lvl_en_q;
    assign evt_en_o  = evt_en_q;
    assign blk_en_o  = blk_en_q;
    assign lvl_clr_o = rd_i && (addr_i == A_LST);
    assign evt_clr_o = rd_i && (addr_i == A_EST);

    // R5
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rvalid_o);
    // R5
    rvalid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rvalid_o);
endmodule

// File: rtl/rx_alarm_irq.sv
module rx_alarm_irq #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int N_LVL   = 6,
    parameter int N_EVT   = 5,
    parameter int BLK_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LVL-1:0]  lvl_in,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              irq
);
    logic [N_LVL-1:0] lvl_chg, lvl_now, lvl_st, lvl_en;
    logic [N_EVT-1:0] evt_st, evt_en;
    logic             blk_en, lvl_clr, evt_clr;

    rxa_change_det #(.N(N_LVL)) u_chg (
        .clk(clk), .rst_n(rst_n), .level_i(lvl_in),
        .chg_o(lvl_chg), .level_q_o(lvl_now)
    );

    rxa_sticky #(.N(N_LVL)) u_lvl_st (
        .clk(clk), .rst_n(rst_n), .set_i(lvl_chg),
        .clr_i(lvl_clr), .sticky_o(lvl_st)
    );

    rxa_sticky #(.N(N_EVT)) u_evt_st (
        .clk(clk), .rst_n(rst_n), .set_i(evt_in),
        .clr_i(evt_clr), .sticky_o(evt_st)
    );

    rxa_regbank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_LVL(N_LVL),
        .N_EVT(N_EVT), .BLK_BIT(BLK_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
        .wdata_i(bus_wdata), .rd_i(bus_rd), .rdata_o(rd_data),
        .rvalid_o(rd_valid), .lvl_st_i(lvl_st), .evt_st_i(evt_st),
        .lvl_now_i(lvl_now), .lvl_en_o(lvl_en), .evt_en_o(evt_en),
        .blk_en_o(blk_en), .lvl_clr_o(lvl_clr), .evt_clr_o(evt_clr)
    );

    assign irq = blk_en & ((|(lvl_st & lvl_en)) | (|(evt_st & evt_en)));

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(bus_rd) || $past(bus_wr)));
    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(lvl_chg) != '0 || $past(evt_in) != '0 || $past(bus_wr)));
endmodule

// File: tb/rx_alarm_irq_bench.sv
module rx_alarm_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] lvl_in = '0;
    logic [4:0] evt_in = '0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    rx_alarm_irq u_rx_alarm_irq (
        .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .evt_in(evt_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(rd_data, 8'hxx, "R5 unexpected response");
            end else begin
                check(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_level(input logic [5:0] v);
        @(negedge clk);
        lvl_in = v;
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [4:0] v);
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({7'b0, irq}, 8'h00, "R1 irq after reset");
        check({7'b0, rd_valid}, 8'h00, "R1 rd_valid after reset");
        bus_read(8'h11, 8'h00, "R1 level status");
        bus_read(8'h13, 8'h00, "R1 event status");
        bus_read(8'h04, 8'h00, "R1 block enable");
        bus_read(8'h10, 8'h00, "R1 level enable");

        set_level(6'h01);
        bus_read(8'h11, 8'h01, "R2 LOS rise R4 not enabled");
        bus_read(8'h11, 8'h00, "R5 cleared by read");
        set_level(6'h00);
        bus_read(8'h11, 8'h01, "R2 LOS fall");
        set_level(6'h2A);
        bus_read(8'h11, 8'h2A, "R2 OOF IDLE AIC rise");
        bus_read(8'h14, 8'h2A, "R8 live levels");

        pulse_evt(5'h15);
        bus_read(8'h13, 8'h15, "R3 event bits");

        bus_write(8'h10, 8'h01);
        set_level(6'h2B);
        check({7'b0, irq}, 8'h00, "R6 block disabled");
        bus_write(8'h04, 8'hFF);
        check({7'b0, irq}, 8'h01, "R6 block enabled pending LOS");
        bus_read(8'h04, 8'h80, "R10 block enable readback");
        bus_read(8'h10, 8'h01, "R10 level enable readback");
        bus_read(8'h20, 8'h00, "R10 unmapped address");
        check({7'b0, irq}, 8'h01, "R4 irq held until read");
        bus_read(8'h11, 8'h01, "R5 pending LOS");
        check({7'b0, irq}, 8'h00, "R7 irq falls after clearing read");

        set_level(6'h29);
        check({7'b0, irq}, 8'h00, "R6 masked source");
        bus_read(8'h11, 8'h02, "R4 masked source latched");

        // same-cycle set and clearing read
        exp_q.push_back(8'h00);
        tag_q.push_back("R9 old value returned");
        @(negedge clk);
        bus_addr = 8'h13;
        bus_rd = 1'b1;
        evt_in = 5'h01;
        @(negedge clk);
        bus_rd = 1'b0;
        evt_in = '0;
        bus_read(8'h13, 8'h01, "R9 bit survives collision");

        bus_write(8'h12, 8'h10);
        pulse_evt(5'h10);
        check({7'b0, irq}, 8'h01, "R6 LAPD enabled");
        bus_write(8'h04, 8'h00);
        check({7'b0, irq}, 8'h00, "R6 block off masks");
        bus_write(8'h04, 8'h80);
        check({7'b0, irq}, 8'h01, "R6 block on again");
        bus_read(8'h12, 8'h10, "R10 event enable readback");
        bus_read(8'h13, 8'h10, "R3 LAPD bit");
        check({7'b0, irq}, 8'h00, "R7 irq falls after event read");

        repeat (3) @(negedge clk);
        check(8'(exp_q.size()), 8'h00, "R5 all responses seen");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule